// File: doc/BRIEF.md
# Scripted Power Sequencer Engine

This block holds a small instruction memory of power-sequence scripts and runs one script whenever a power event is raised. There are four event classes: warm reset, wakeup of processor groups 1 and 2, wakeup of group 3, and entry to sleep. Each class has its own programmable entry index into the script memory. Each instruction carries a 16-bit power-bus message, a delay byte and a next-instruction index. The engine issues the message, waits out the delay in prescaled ticks, and then follows the next index until it reaches the terminator value.

A host loads the memory and the control registers through a simple byte write port. Script memory is written indirectly: the host first writes a byte address, then the data byte. Per-group event control registers choose whether a group's wakeup input is level- or edge-sensitive, and whether that group may launch the warm-reset script. An event that arrives while a script runs is held pending and starts only after the running script terminates, in a fixed priority order.

Top module: `pwr_script_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `busy` and `msg_valid` are 0, and no message is issued until an event is raised.
- R2: A write with `cfg_sel`=0 stores a byte address and a write with `cfg_sel`=1 stores the data byte at that address. The instruction with index i occupies bytes 4i to 4i+3: message bits 15:8, message bits 7:0, delay, next index.
- R3: Each instruction issues its message on `msg` together with a `msg_valid` strobe that lasts exactly one cycle, and only while `busy` is high.
- R4: The low 6 bits of the next byte select the following instruction. The value 0x3F ends the script, after which `busy` falls.
- R5: With a delay byte d ≥ 1, the next strobe follows d·TICK_DIV+2 cycles after the previous one. After the last instruction, `busy` falls d·TICK_DIV cycles after its strobe.
- R6: A delay byte of 0 waits one tick, the same as a delay of 1.
- R7: Writes with `cfg_sel` 2, 3, 4 and 5 set the first instruction index of the sleep, group-1/2 wakeup, group-3 wakeup and warm-reset scripts.
- R8: Writes with `cfg_sel` 6, 7 and 8 set the event control of groups 1, 2 and 3. Bit 3 selects level-sensitive wakeup and bit 4 enables warm reset. A `warm_req` bit whose group has bit 4 clear has no effect.
- R9: With bit 3 clear, a wakeup input held high launches one run. With bit 3 set, the script runs again and again for as long as the input is held high.
- R10: Events raised while a script runs are queued and start after the terminator, in this order: warm reset, group-1/2 wakeup, group-3 wakeup, sleep.
- R11: A wakeup of group 1 or group 2 runs the group-1/2 wakeup script. A wakeup of group 3 runs the group-3 wakeup script.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe |
| cfg_sel | input | 4 | Host register select |
| cfg_wdata | input | 8 | Host write byte |
| sleep_req | input | 1 | Sleep event pulse |
| wake_in | input | NGRP (3) | Per-group wakeup inputs (bit 0 = group 1) |
| warm_req | input | NGRP (3) | Per-group warm-reset request pulses |
| busy | output | 1 | High from event acceptance until the terminator |
| msg_valid | output | 1 | One-cycle strobe for an issued message |
| msg | output | 16 | Issued power-bus message |

## Verification
On every cycle the assertions check the strobe shape: a single-cycle `msg_valid` that only appears under `busy`. They also check the minimum spacing of one tick plus the fetch between strobes, that a new script is accepted only while idle, and that the block is quiet after reset. Other behaviour can only be shown by the bench's scenarios: the messages a script emits, the exact delay arithmetic, the zero-delay case, the link order and the terminator, which entry index each event class uses, level and edge wakeup, ignored warm requests, and the order in which queued events run.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int CFG_SEL_W = 4;

  localparam logic [CFG_SEL_W-1:0] SEL_MEM_ADDR   = 4'd0;
  localparam logic [CFG_SEL_W-1:0] SEL_MEM_DATA   = 4'd1;
  localparam logic [CFG_SEL_W-1:0] SEL_ST_SLEEP   = 4'd2;
  localparam logic [CFG_SEL_W-1:0] SEL_ST_WAKE12  = 4'd3;
  localparam logic [CFG_SEL_W-1:0] SEL_ST_WAKE3   = 4'd4;
  localparam logic [CFG_SEL_W-1:0] SEL_ST_WARM    = 4'd5;
  localparam logic [CFG_SEL_W-1:0] SEL_GRP_BASE   = 4'd6;

  localparam int BIT_LVL_WAKE = 3;
  localparam int BIT_WARM_EN  = 4;

  localparam int NUM_CLASS = 4;

  // index order is the priority order (lowest index wins)
  typedef enum logic [1:0] {
    EV_WARM   = 2'd0,
    EV_WAKE12 = 2'd1,
    EV_WAKE3  = 2'd2,
    EV_SLEEP  = 2'd3
  } ev_class_e;

  // byte lanes of one instruction word
  localparam int LANE_MSG_HI = 0;
  localparam int LANE_MSG_LO = 1;
  localparam int LANE_DELAY  = 2;
  localparam int LANE_NEXT   = 3;
  localparam int LANES       = 4;
endpackage

// File: rtl/pss_cfg_regs.sv
module pss_cfg_regs
  import pss_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int NGRP  = 3,
  localparam int AW   = IDX_W + 2
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cfg_we,
  input  logic [CFG_SEL_W-1:0]                cfg_sel,
  input  logic [7:0]                          cfg_wdata,
  output logic                                mem_we,
  output logic [AW-1:0]                       mem_waddr,
  output logic [7:0]                          mem_wdata,
  output logic [NUM_CLASS-1:0][IDX_W-1:0]     start_tab,
  output logic [NGRP-1:0]                     lvl_en,
  output logic [NGRP-1:0]                     warm_en
);
  assign mem_we    = cfg_we && (cfg_sel == SEL_MEM_DATA);
  assign mem_wdata = cfg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_waddr <= '0;
      start_tab <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_MEM_ADDR:  mem_waddr           <= cfg_wdata[AW-1:0];
        SEL_ST_SLEEP:  start_tab[EV_SLEEP]  <= cfg_wdata[IDX_W-1:0];
        SEL_ST_WAKE12: start_tab[EV_WAKE12] <= cfg_wdata[IDX_W-1:0];
        SEL_ST_WAKE3:  start_tab[EV_WAKE3]  <= cfg_wdata[IDX_W-1:0];
        SEL_ST_WARM:   start_tab[EV_WARM]   <= cfg_wdata[IDX_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam logic [CFG_SEL_W-1:0] MY_SEL = SEL_GRP_BASE + CFG_SEL_W'(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_en[g]  <= 1'b0;
        warm_en[g] <= 1'b0;
      end else if (cfg_we && cfg_sel == MY_SEL) begin
        lvl_en[g]  <= cfg_wdata[BIT_LVL_WAKE];
        warm_en[g] <= cfg_wdata[BIT_WARM_EN];
      end
    end
  end
endmodule

// File: rtl/pss_script_mem.sv
module pss_script_mem
  import pss_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int AW    = IDX_W + 2,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [AW-1:0]         waddr,
  input  logic [7:0]            wdata,
  input  logic [IDX_W-1:0]      raddr,
  output logic [LANES-1:0][7:0] rdata
);
  // one narrow RAM per byte lane: a whole instruction reads in one cycle
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] ram [DEPTH];
    always_ff @(posedge clk) begin
      if (we && waddr[1:0] == 2'(l))
        ram[waddr[AW-1:2]] <= wdata;
      rdata[l] <= ram[raddr];
    end
  end
endmodule

// File: rtl/pss_event_arb.sv
module pss_event_arb
  import pss_pkg::*;
#(
  parameter int NGRP = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            eng_idle,
  input  logic            sleep_req,
  input  logic [NGRP-1:0] wake_in,
  input  logic [NGRP-1:0] warm_req,
  input  logic [NGRP-1:0] lvl_en,
  input  logic [NGRP-1:0] warm_en,
  output logic            take,
  output ev_class_e       cls
);
  logic [NUM_CLASS-1:0] pend, set_v, clr_v;
  logic [NGRP-1:0]      wake_prev, wake_hit;

  assign wake_hit = (lvl_en & wake_in) | (~lvl_en & wake_in & ~wake_prev);

  always_comb begin
    set_v            = '0;
    set_v[EV_WARM]   = |(warm_req & warm_en);
    set_v[EV_WAKE12] = |wake_hit[NGRP-2:0];
    set_v[EV_WAKE3]  = wake_hit[NGRP-1];
    set_v[EV_SLEEP]  = sleep_req;
  end

  always_comb begin
    cls = EV_SLEEP;
    for (int i = NUM_CLASS - 1; i >= 0; i--)
      if (pend[i]) cls = ev_class_e'(2'(i));
  end

  assign take = eng_idle && (|pend);

  always_comb begin
    clr_v = '0;
    if (take) clr_v[cls] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= '0;
      wake_prev <= '0;
    end else begin
      pend      <= (pend & ~clr_v) | set_v;
      wake_prev <= wake_in;
    end
  end
endmodule

// File: rtl/pss_engine.sv
module pss_engine
  import pss_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int TICK_DIV = 32,
  localparam int PRE_W   = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1,
  localparam logic [IDX_W-1:0] TERM = {IDX_W{1'b1}}
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [IDX_W-1:0]      start_idx,
  input  logic [LANES-1:0][7:0] rdata,
  output logic [IDX_W-1:0]      raddr,
  output logic                  idle,
  output logic                  busy,
  output logic                  msg_valid,
  output logic [15:0]           msg
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_ISSUE, S_WAIT} st_e;

  st_e              st;
  logic [IDX_W-1:0] idx, nxt;
  logic [7:0]       cnt;
  logic [PRE_W-1:0] pre;
  logic             tick;

  assign raddr = idx;
  assign idle  = (st == S_IDLE);
  assign tick  = (pre == PRE_W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      idx       <= '0;
      nxt       <= '0;
      cnt       <= '0;
      pre       <= '0;
      busy      <= 1'b0;
      msg_valid <= 1'b0;
      msg       <= '0;
    end else begin
      msg_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            idx  <= start_idx;
            busy <= 1'b1;
            st   <= S_READ;
          end
        end
        S_READ: st <= S_ISSUE;
        S_ISSUE: begin
          msg       <= {rdata[LANE_MSG_HI], rdata[LANE_MSG_LO]};
          msg_valid <= 1'b1;
          cnt       <= (rdata[LANE_DELAY] == 8'd0) ? 8'd1 : rdata[LANE_DELAY];
          nxt       <= rdata[LANE_NEXT][IDX_W-1:0];
          pre       <= '0;
          st        <= S_WAIT;
        end
        S_WAIT: begin
          if (tick) begin
            pre <= '0;
            if (cnt == 8'd1) begin
              if (nxt == TERM) begin
                busy <= 1'b0;
                st   <= S_IDLE;
              end else begin
                idx <= nxt;
                st  <= S_READ;
              end
            end else begin
              cnt <= cnt - 8'd1;
            end
          end else begin
            pre <= pre + PRE_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_script_seq.sv
module pwr_script_seq
  import pss_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int TICK_DIV = 32,
  parameter int NGRP     = 3,
  localparam int AW      = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [CFG_SEL_W-1:0] cfg_sel,
  input  logic [7:0]           cfg_wdata,
  input  logic                 sleep_req,
  input  logic [NGRP-1:0]      wake_in,
  input  logic [NGRP-1:0]      warm_req,
  output logic                 busy,
  output logic                 msg_valid,
  output logic [15:0]          msg
);
  logic                            mem_we;
  logic [AW-1:0]                   mem_waddr;
  logic [7:0]                      mem_wdata;
  logic [NUM_CLASS-1:0][IDX_W-1:0] start_tab;
  logic [NGRP-1:0]                 lvl_en, warm_en;
  logic [IDX_W-1:0]                raddr;
  logic [LANES-1:0][7:0]           rdata;
  logic                            eng_idle, arb_take;
  ev_class_e                       arb_cls;

  pss_cfg_regs #(.IDX_W(IDX_W), .NGRP(NGRP)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .start_tab(start_tab), .lvl_en(lvl_en),
    .warm_en(warm_en)
  );

  pss_script_mem #(.IDX_W(IDX_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  pss_event_arb #(.NGRP(NGRP)) u_arb (
    .clk(clk), .rst(rst), .eng_idle(eng_idle), .sleep_req(sleep_req),
    .wake_in(wake_in), .warm_req(warm_req), .lvl_en(lvl_en),
    .warm_en(warm_en), .take(arb_take), .cls(arb_cls)
  );

  pss_engine #(.IDX_W(IDX_W), .TICK_DIV(TICK_DIV)) u_eng (
    .clk(clk), .rst(rst), .start(arb_take), .start_idx(start_tab[arb_cls]),
    .rdata(rdata), .raddr(raddr), .idle(eng_idle), .busy(busy),
    .msg_valid(msg_valid), .msg(msg)
  );
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int TICK_DIV = 32
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic msg_valid,
  input logic take
);
  // cycles since the last strobe, saturating
  logic [15:0] gap;
  always_ff @(posedge clk) begin
    if (rst)            gap <= 16'hFFFF;
    else if (msg_valid) gap <= 16'd1;
    else if (gap != 16'hFFFF) gap <= gap + 16'd1;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!busy && !msg_valid));

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    msg_valid |=> !msg_valid);

  p_strobe_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> busy);

  p_strobe_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> (gap >= 16'(TICK_DIV + 2)));

  p_accept_idle_r10: assert property (@(posedge clk) disable iff (rst)
    take |-> !busy);
endmodule

bind pwr_script_seq pss_checker #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .msg_valid(msg_valid), .take(arb_take)
);

// File: tb/test_pwr_script_seq.sv
`timescale 1ns/1ps
module test_pwr_script_seq;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        sleep_req = 1'b0;
  logic [2:0]  wake_in = '0;
  logic [2:0]  warm_req = '0;
  logic        busy, msg_valid;
  logic [15:0] msg;

  pwr_script_seq #(.IDX_W(6), .TICK_DIV(DIV), .NGRP(3)) i_pwr_script_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sleep_req(sleep_req), .wake_in(wake_in),
    .warm_req(warm_req), .busy(busy), .msg_valid(msg_valid), .msg(msg)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // output monitor, sampled away from the active edge
  logic [15:0] cap_msg [256];
  int          cap_t   [256];
  int          ncap = 0, nrise = 0, fall_t = 0;
  logic        busy_d = 1'b0;
  always @(negedge clk) begin
    if (msg_valid && ncap < 256) begin
      cap_msg[ncap] = msg;
      cap_t[ncap]   = cyc;
      ncap++;
    end
    if (busy && !busy_d) nrise++;
    if (!busy && busy_d) fall_t = cyc;
    busy_d = busy;
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int sel, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = 8'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put_ins(input int idx, input logic [15:0] m,
                         input int d, input int nx);
    wr(0, idx*4);     wr(1, m[15:8]);
    wr(0, idx*4 + 1); wr(1, m[7:0]);
    wr(0, idx*4 + 2); wr(1, d);
    wr(0, idx*4 + 3); wr(1, nx);
  endtask

  // 0 sleep, 1..3 wake group 1..3, 4..6 warm group 1..3
  task automatic fire(input int ev);
    @(negedge clk);
    if (ev == 0)      sleep_req = 1'b1;
    else if (ev <= 3) wake_in[ev-1] = 1'b1;
    else              warm_req[ev-4] = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0; wake_in = '0; warm_req = '0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    int guard = 0;
    while (quiet < 4 && guard < 5000) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
      guard++;
    end
  endtask

  // {event, count, first message, last message}
  localparam logic [39:0] TBL [6] = '{
    {4'd0, 4'd3, 16'hA101, 16'hA103},
    {4'd1, 4'd2, 16'hB201, 16'hB202},
    {4'd2, 4'd2, 16'hB201, 16'hB202},
    {4'd3, 4'd1, 16'hC301, 16'hC301},
    {4'd4, 4'd2, 16'hD401, 16'hD402},
    {4'd6, 4'd2, 16'hD401, 16'hD402}
  };

  localparam logic [15:0] PRIO_EXP [11] = '{
    16'hA101, 16'hA102, 16'hA103, 16'hD401, 16'hD402,
    16'hB201, 16'hB202, 16'hC301, 16'hA101, 16'hA102, 16'hA103
  };

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base, r0, got;
    repeat (5) @(negedge clk);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 strobe in reset", int'(msg_valid), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", int'(busy), 0);
    chk("R1 no message", ncap, 0);

    // R2: scripts placed back to back from index 0x2B
    put_ins(43, 16'hA101, 2, 44);
    put_ins(44, 16'hA102, 0, 45);
    put_ins(45, 16'hA103, 1, 8'h3F);
    put_ins(46, 16'hB201, 1, 47);
    put_ins(47, 16'hB202, 3, 8'h3F);
    put_ins(48, 16'hC301, 1, 8'h3F);
    put_ins(49, 16'hD401, 2, 50);
    put_ins(50, 16'hD402, 1, 8'h3F);
    // R7 entry indices, R8 group controls
    wr(2, 43); wr(3, 46); wr(4, 48); wr(5, 49);
    wr(6, 8'h10); wr(7, 8'h00); wr(8, 8'h10);

    // vector walk: R2 R4 R7 R11
    for (int k = 0; k < 6; k++) begin
      base = ncap;
      fire(int'(TBL[k][39:36]));
      wait_idle();
      chk($sformatf("R4 count vec%0d", k), ncap - base, int'(TBL[k][35:32]));
      chk($sformatf("R7 R11 first vec%0d", k), int'(cap_msg[base]), int'(TBL[k][31:16]));
      chk($sformatf("R2 last vec%0d", k), int'(cap_msg[ncap-1]), int'(TBL[k][15:0]));
    end

    // delay arithmetic R5 and zero delay R6
    base = ncap;
    fire(0);
    wait_idle();
    chk("R5 gap d=2", cap_t[base+1] - cap_t[base], 2*DIV + 2);
    chk("R6 gap d=0", cap_t[base+2] - cap_t[base+1], DIV + 2);
    chk("R5 busy fall after last", fall_t - cap_t[base+2], DIV);

    // R8: warm request of group 2 (bit 4 clear) is ignored
    base = ncap; r0 = nrise;
    fire(5);
    repeat (20) @(negedge clk);
    chk("R8 ignored warm msgs", ncap - base, 0);
    chk("R8 ignored warm busy", nrise - r0, 0);

    // R9 edge mode: held high gives one run
    base = ncap;
    @(negedge clk); wake_in[0] = 1'b1;
    repeat (100) @(negedge clk);
    chk("R9 edge one run", ncap - base, 2);
    wake_in[0] = 1'b0;
    repeat (4) @(negedge clk);

    // R9 level mode: reruns while held
    wr(6, 8'h18);
    base = ncap;
    @(negedge clk); wake_in[0] = 1'b1;
    repeat (60) @(negedge clk);
    wake_in[0] = 1'b0;
    wait_idle();
    got = ncap - base;
    chk("R9 level reruns", int'(got >= 4), 1);
    chk("R9 level whole runs", got % 2, 0);
    wr(6, 8'h10);
    wait_idle();

    // R10 priority of queued events
    base = ncap;
    fire(0);
    repeat (3) @(negedge clk);
    warm_req[0] = 1'b1; wake_in[0] = 1'b1; wake_in[2] = 1'b1; sleep_req = 1'b1;
    @(negedge clk);
    warm_req = '0; wake_in = '0; sleep_req = 1'b0;
    wait_idle();
    chk("R10 queued count", ncap - base, 11);
    for (int j = 0; j < 11; j++)
      chk($sformatf("R10 order %0d", j), int'(cap_msg[base+j]), int'(PRIO_EXP[j]));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule